// File: doc/BRIEF.md
# Error record copy engine

This engine moves a single error record between a byte-wide exchange buffer and one fixed-size slot of a byte-wide record store. For a write it takes the record found at a given offset in the exchange buffer. It reads the record's length and identifier from the record header and checks both. It asks an external slot-map block which slot to use, then copies the record into that slot byte by byte. The slot bytes past the end of the record are set to 0xFF. For a read it resolves the requested identifier, asks the slot map for the slot, checks the length stored in the slot, and copies the record back into the exchange buffer at the given offset.

Both memories are simple synchronous byte memories with one cycle of read latency. The engine makes at most one access to each memory per cycle. The slot map answers a held request with an acknowledge pulse that carries hit, slot and full information. The slot map also supplies an empty-store flag and the identifier of the first stored record. Each operation ends with a one-cycle `done` pulse that carries a status code. The slot map uses the `rec_added` flag on that pulse to update its record count.

Top module: `err_rec_copier`

## Requirements
- R1: If the record offset is greater than BUF_BYTES-128, the operation ends with status 0x03 and neither memory is written. A read first applies its R7 and R8 checks.
- R2: For a write, the record length is the little-endian 32-bit value at byte offset 20 of the record. A length below 128, or above BUF_BYTES minus the offset, ends the write with status 0x03.
- R3: For a write, the identifier is the little-endian 64-bit value at byte offset 96 of the record. An identifier that is all zeros or all ones ends the write with status 0x03.
- R4: If the slot map reports a hit, a write overwrites the returned slot and `rec_added` is 0. On a miss with a free slot, the write uses the returned slot and `rec_added` is 1. `rec_slot` reports the slot used.
- R5: A write that misses while the slot map reports full ends with status 0x01 and writes no slot.
- R6: A successful write copies the record bytes 0 to len-1 into slot bytes 0 to len-1, and sets slot bytes len to BUF_BYTES-1 to 0xFF.
- R7: A read while the store is empty ends with status 0x04.
- R8: A read with an all-zeros identifier uses `first_id` instead. If the resulting identifier is all ones, the read ends with status 0x03. `rec_id_out` shows the resolved identifier.
- R9: A read whose identifier misses in the slot map ends with status 0x05, and `rec_id_out` shows `first_id`.
- R10: On a read hit, the length is taken from bytes 20 to 23 of the slot, little-endian, and checked as in R2 (status 0x03). Otherwise the slot bytes 0 to len-1 are copied to exchange bytes offset to offset+len-1, and the status is 0x00. The store is never written during a read.
- R11: `done` is a single-cycle pulse that carries `status`, and 0x00 means success. `map_req` stays high until `map_ack`. After reset, `done`, `map_req` and both write enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| op_read | input | 1 | 1 = read record, 0 = write record |
| rec_offset | input | 32 | Byte offset of the record in the exchange buffer |
| rec_id_in | input | 64 | Requested identifier for reads |
| done | output | 1 | One-cycle completion pulse |
| status | output | 8 | Completion code, valid with done |
| rec_id_out | output | 64 | Resolved identifier, valid with done |
| rec_added | output | 1 | Write created a new record, valid with done |
| rec_slot | output | SLOT_W | Slot used, valid with done |
| map_req | output | 1 | Slot lookup request, held until acknowledged |
| map_id | output | 64 | Identifier to look up |
| map_ack | input | 1 | Lookup response strobe |
| map_hit | input | 1 | Identifier found in the map |
| map_full | input | 1 | No empty slot left |
| map_slot | input | SLOT_W | Slot holding the identifier, or the first free one |
| store_empty | input | 1 | No record stored |
| first_id | input | 64 | Identifier of the first stored record |
| xb_addr | output | AW | Exchange buffer byte address |
| xb_we | output | 1 | Exchange buffer write enable |
| xb_wdata | output | 8 | Exchange buffer write data |
| xb_rdata | input | 8 | Exchange buffer read data, one cycle after address |
| st_addr | output | SLOT_W+AW | Store byte address, slot in the upper bits |
| st_we | output | 1 | Store write enable |
| st_wdata | output | 8 | Store write data |
| st_rdata | input | 8 | Store read data, one cycle after address |

## Verification
The bench builds the engine with BUF_BYTES=256 and SLOT_W=2. A 256-byte buffer puts both ends of the record length range within a few hundred cycles: the 128-byte minimum at the top offset of 128, and a full-buffer record that leaves no 0xFF tail. Four slots let the bench fill the store and reach the not-enough-space path. They also leave room for a slot with a corrupted stored length, used for the read-side length check.

// File: rtl/err_rec_copier.sv
module err_rec_copier #(
  parameter int BUF_BYTES = 256,
  parameter int SLOT_W = 2,
  localparam int AW = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_read,
  input  logic [31:0]       rec_offset,
  input  logic [63:0]       rec_id_in,
  output logic              done,
  output logic [7:0]        status,
  output logic [63:0]       rec_id_out,
  output logic              rec_added,
  output logic [SLOT_W-1:0] rec_slot,
  output logic              map_req,
  output logic [63:0]       map_id,
  input  logic              map_ack,
  input  logic              map_hit,
  input  logic              map_full,
  input  logic [SLOT_W-1:0] map_slot,
  input  logic              store_empty,
  input  logic [63:0]       first_id,
  output logic [AW-1:0]     xb_addr,
  output logic              xb_we,
  output logic [7:0]        xb_wdata,
  input  logic [7:0]        xb_rdata,
  output logic [SLOT_W+AW-1:0] st_addr,
  output logic              st_we,
  output logic [7:0]        st_wdata,
  input  logic [7:0]        st_rdata
);
  localparam int MIN_REC = 128;
  localparam logic [31:0] OFS_MAX = 32'(BUF_BYTES - MIN_REC);
  localparam logic [AW:0] FULL_LEN = (AW+1)'(BUF_BYTES);
  localparam logic [AW:0] LAST = (AW+1)'(BUF_BYTES - 1);

  typedef enum logic [2:0] {S_IDLE, S_LEN, S_ID, S_MAP, S_COPY, S_FILL} state_t;
  state_t state;

  logic [AW:0]       cnt, len;
  logic [AW-1:0]     ofs;
  logic [63:0]       acc, id;
  logic              is_rd, hit, dn, added;
  logic [SLOT_W-1:0] slot;
  logic [7:0]        sts;

  wire [7:0]  in_byte = is_rd ? st_rdata : xb_rdata;
  wire [31:0] len_now = {in_byte, acc[63:40]};
  wire [63:0] id_now  = {in_byte, acc[63:8]};
  wire [32:0] room    = 33'(BUF_BYTES) - {25'd0, ofs};
  wire        len_bad = (len_now < 32'(MIN_REC)) || ({1'b0, len_now} > room);
  wire [63:0] rid     = (rec_id_in == '0) ? first_id : rec_id_in;
  wire [AW:0] cnt_m1  = cnt - 1'b1;
  wire [AW:0] fld     = (state == S_ID) ? (AW+1)'(96) : (AW+1)'(20);
  wire        wr_copy = (state == S_COPY) && !is_rd;
  wire        rd_copy = (state == S_COPY) && is_rd;
  wire [AW:0] xb_off  = rd_copy ? cnt_m1 : (wr_copy ? cnt : fld + cnt);
  wire [AW:0] st_off  = wr_copy ? cnt_m1 : ((state == S_LEN) ? fld + cnt : cnt);
  wire [AW:0] xb_sum  = {1'b0, ofs} + xb_off;

  assign xb_addr    = xb_sum[AW-1:0];
  assign xb_we      = rd_copy && (cnt != '0);
  assign xb_wdata   = st_rdata;
  assign st_addr    = {slot, st_off[AW-1:0]};
  assign st_we      = (wr_copy && (cnt != '0)) || (state == S_FILL);
  assign st_wdata   = (state == S_FILL) ? 8'hFF : xb_rdata;
  assign map_req    = (state == S_MAP);
  assign map_id     = id;
  assign done       = dn;
  assign status     = sts;
  assign rec_id_out = id;
  assign rec_added  = added;
  assign rec_slot   = slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt <= '0; len <= '0; ofs <= '0; acc <= '0; id <= '0;
      is_rd <= 1'b0; hit <= 1'b0; slot <= '0; sts <= '0; dn <= 1'b0; added <= 1'b0;
    end else begin
      dn <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          is_rd <= op_read;
          ofs   <= rec_offset[AW-1:0];
          cnt   <= '0;
          added <= 1'b0;
          if (op_read) begin
            id <= rid;
            if (store_empty) begin dn <= 1'b1; sts <= 8'h04; end
            else if (&rid || rec_offset > OFS_MAX) begin dn <= 1'b1; sts <= 8'h03; end
            else state <= S_MAP;
          end else if (rec_offset > OFS_MAX) begin
            dn <= 1'b1; sts <= 8'h03;
          end else state <= S_LEN;
        end
        S_LEN, S_ID: begin
          acc <= id_now;
          cnt <= cnt + 1'b1;
          if (state == S_LEN && cnt == (AW+1)'(4)) begin
            cnt <= '0;
            if (len_bad) begin state <= S_IDLE; dn <= 1'b1; sts <= 8'h03; end
            else begin len <= len_now[AW:0]; state <= is_rd ? S_COPY : S_ID; end
          end else if (state == S_ID && cnt == (AW+1)'(8)) begin
            cnt <= '0;
            if (id_now == '0 || &id_now) begin state <= S_IDLE; dn <= 1'b1; sts <= 8'h03; end
            else begin id <= id_now; state <= S_MAP; end
          end
        end
        S_MAP: if (map_ack) begin
          hit  <= map_hit;
          slot <= map_slot;
          if (is_rd) begin
            if (!map_hit) begin id <= first_id; state <= S_IDLE; dn <= 1'b1; sts <= 8'h05; end
            else state <= S_LEN;
          end else if (map_hit || !map_full) state <= S_COPY;
          else begin state <= S_IDLE; dn <= 1'b1; sts <= 8'h01; end
        end
        S_COPY: if (cnt == len) begin
          if (!is_rd && len != FULL_LEN) state <= S_FILL;
          else begin state <= S_IDLE; dn <= 1'b1; sts <= 8'h00; added <= !is_rd && !hit; end
        end else cnt <= cnt + 1'b1;
        S_FILL: if (cnt == LAST) begin
          state <= S_IDLE; dn <= 1'b1; sts <= 8'h00; added <= !hit;
        end else cnt <= cnt + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n) map_req && !map_ack |=> map_req);
  a_r1_offset_reject: assert property (@(posedge clk) disable iff (!rst_n)
    start && state == S_IDLE && !op_read && rec_offset > OFS_MAX |=> done && status == 8'h03);
  a_r7_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    start && state == S_IDLE && op_read && store_empty |=> done && status == 8'h04);
  a_r5_full_reject: assert property (@(posedge clk) disable iff (!rst_n)
    map_req && map_ack && !is_rd && !map_hit && map_full |=> done && status == 8'h01);
  a_r10_no_store_write_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> !is_rd && !xb_we);
endmodule

// File: tb/err_rec_copier_test.sv
module err_rec_copier_test;
  localparam int BUF = 256;
  localparam int SW = 2;
  localparam int NS = 4;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic start = 1'b0, op_read = 1'b0;
  logic [31:0] rec_offset = '0;
  logic [63:0] rec_id_in = '0;
  logic done, rec_added, map_req, map_ack, map_hit, map_full, store_empty;
  logic [7:0] status;
  logic [63:0] rec_id_out, map_id, first_id;
  logic [SW-1:0] rec_slot, map_slot;
  logic [AW-1:0] xb_addr;
  logic xb_we, st_we;
  logic [7:0] xb_wdata, xb_rdata, st_wdata, st_rdata;
  logic [SW+AW-1:0] st_addr;

  err_rec_copier #(.BUF_BYTES(BUF), .SLOT_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_read(op_read), .rec_offset(rec_offset),
    .rec_id_in(rec_id_in), .done(done), .status(status), .rec_id_out(rec_id_out),
    .rec_added(rec_added), .rec_slot(rec_slot), .map_req(map_req), .map_id(map_id),
    .map_ack(map_ack), .map_hit(map_hit), .map_full(map_full), .map_slot(map_slot),
    .store_empty(store_empty), .first_id(first_id), .xb_addr(xb_addr), .xb_we(xb_we),
    .xb_wdata(xb_wdata), .xb_rdata(xb_rdata), .st_addr(st_addr), .st_we(st_we),
    .st_wdata(st_wdata), .st_rdata(st_rdata));

  logic [7:0] xb [0:BUF-1];
  logic [7:0] st [0:NS*BUF-1];
  logic [63:0] ids [0:NS-1];
  logic [NS-1:0] vld = '0;
  logic [31:0] pq [$];
  logic [31:0] pk;

  function automatic logic [SW+1:0] look(input logic [63:0] q);
    logic [SW+1:0] r;
    r = {1'b0, SW'(0), &vld};
    for (int i = NS - 1; i >= 0; i--) if (!vld[i]) r[SW:1] = SW'(i);
    for (int i = 0; i < NS; i++) if (vld[i] && ids[i] == q) begin r[SW+1] = 1'b1; r[SW:1] = SW'(i); end
    return r;
  endfunction

  function automatic logic [63:0] first_stored();
    logic [63:0] f;
    f = '1;
    for (int i = NS - 1; i >= 0; i--) if (vld[i]) f = ids[i];
    return f;
  endfunction

  always @(posedge clk) begin
    while (pq.size() > 0) begin
      pk = pq.pop_front();
      if (pk[31]) st[pk[17:8]] = pk[7:0]; else xb[pk[15:8]] = pk[7:0];
    end
    xb_rdata <= xb[xb_addr];
    if (xb_we) xb[xb_addr] <= xb_wdata;
    st_rdata <= st[st_addr];
    if (st_we) st[st_addr] <= st_wdata;
    store_empty <= (vld == '0);
    first_id <= first_stored();
    if (map_req && !map_ack) begin
      map_ack <= 1'b1;
      {map_hit, map_slot, map_full} <= look(map_id);
    end else map_ack <= 1'b0;
  end

  typedef struct {
    string tag; logic [7:0] s; bit cid; logic [63:0] id; bit cslot; logic [SW-1:0] slot; logic added;
  } exp_t;
  exp_t sbq [$];
  exp_t got;
  int nchk = 0, nbad = 0, npush = 0, npop = 0;
  bit ended = 1'b0;

  always @(negedge clk) if (rst_n && done) begin
    nchk++;
    if (sbq.size() == 0) begin
      nbad++; $display("FAIL R11 unexpected done: actual status %h expected none", status);
    end else begin
      got = sbq.pop_front();
      if (status !== got.s || (got.cid && rec_id_out !== got.id) ||
          (got.cslot && (rec_slot !== got.slot || rec_added !== got.added))) begin
        nbad++;
        $display("FAIL %s: actual st=%h id=%h slot=%0d add=%0d expected st=%h id=%h slot=%0d add=%0d",
                 got.tag, status, rec_id_out, rec_slot, rec_added, got.s, got.id, got.slot, got.added);
      end
    end
    npop++;
  end

  task automatic chk(input string tag, input bit ok, input longint act, input longint expv);
    nchk++;
    if (!ok) begin nbad++; $display("FAIL %s: actual %0d expected %0d", tag, act, expv); end
  endtask

  task automatic build(input int ofs, input int len, input logic [63:0] wid, input int seed);
    for (int i = 0; i < len && ofs + i < BUF; i++) pq.push_back({16'h0, 8'(ofs + i), 8'(seed + i * 7)});
    for (int k = 0; k < 4; k++) if (ofs + 20 + k < BUF) pq.push_back({16'h0, 8'(ofs + 20 + k), 8'(len >> (8 * k))});
    for (int k = 0; k < 8; k++) if (ofs + 96 + k < BUF) pq.push_back({16'h0, 8'(ofs + 96 + k), 8'(wid >> (8 * k))});
    @(negedge clk); @(negedge clk);
  endtask

  task automatic run(input string tag, input bit rd, input int ofs, input logic [63:0] rqid,
                     input int len, input logic [63:0] wid);
    exp_t e;
    logic [SW+1:0] lk;
    logic [63:0] r;
    longint slen;
    int base, bad;
    e.tag = tag; e.cid = 0; e.cslot = 0; e.id = '0; e.slot = '0; e.added = 0; e.s = 8'h00;
    if (!rd) begin
      build(ofs, len, wid, ofs + len);
      lk = look(wid);
      if (ofs > BUF - 128 || len < 128 || len > BUF - ofs || wid == '0 || &wid) e.s = 8'h03;
      else if (!lk[SW+1] && lk[0]) e.s = 8'h01;
      else begin e.cslot = 1; e.slot = lk[SW:1]; e.added = !lk[SW+1]; end
    end else begin
      r = (rqid == '0) ? first_stored() : rqid;
      e.cid = 1; e.id = r;
      lk = look(r);
      if (vld == '0) begin e.s = 8'h04; e.cid = 0; end
      else if (&r || ofs > BUF - 128) e.s = 8'h03;
      else if (!lk[SW+1]) begin e.s = 8'h05; e.id = first_stored(); end
      else begin
        base = int'(lk[SW:1]) * BUF;
        slen = longint'({st[base+23], st[base+22], st[base+21], st[base+20]});
        if (slen < 128 || slen > BUF - ofs) e.s = 8'h03;
      end
    end
    sbq.push_back(e); npush++;
    op_read = rd; rec_offset = 32'(ofs); rec_id_in = rqid; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait (npop == npush);
    @(negedge clk);
    if (!rd && e.s == 8'h00) begin
      base = int'(e.slot) * BUF; bad = 0;
      for (int i = 0; i < BUF; i++)
        if (st[base + i] !== ((i < len) ? xb[ofs + i] : 8'hFF)) bad++;
      chk({tag, " R6 slot image"}, bad == 0, bad, 0);
      vld[e.slot] = 1'b1; ids[e.slot] = wid;
    end
    if (rd && e.s == 8'h00) begin
      base = int'(lk[SW:1]) * BUF; bad = 0;
      slen = longint'({st[base+23], st[base+22], st[base+21], st[base+20]});
      for (int i = 0; i < slen; i++) if (xb[ofs + i] !== st[base + i]) bad++;
      chk({tag, " R10 exchange image"}, bad == 0, bad, 0);
    end
    @(negedge clk);
  endtask

  localparam logic [63:0] ID_A = 64'h1111_2222_3333_4444;
  localparam logic [63:0] ID_B = 64'hA5A5_0000_0000_5A5A;
  localparam logic [63:0] ID_C = 64'h0000_0000_0000_0001;
  localparam logic [63:0] ID_D = 64'hFFFF_FFFF_FFFF_FFFE;
  localparam logic [63:0] ID_E = 64'h0123_4567_89AB_CDEF;

  initial begin
    for (int i = 0; i < BUF; i++) xb[i] = 8'h00;
    for (int i = 0; i < NS * BUF; i++) st[i] = 8'h00;
    for (int i = 0; i < NS; i++) ids[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset outputs", done == 0 && map_req == 0 && st_we == 0 && xb_we == 0,
        {done, map_req, st_we, xb_we}, 0);
    run("R7 read on empty store", 1, 0, 64'h5, 0, 0);
    run("R4 R6 new record A", 0, 0, 0, 150, ID_A);
    run("R6 new record B at offset 16", 0, 16, 0, 200, ID_B);
    run("R4 overwrite A full buffer", 0, 0, 0, 256, ID_A);
    run("R1 write offset 129", 0, 129, 0, 128, ID_C);
    run("R1 R2 write offset 128 min length", 0, 128, 0, 128, ID_C);
    run("R2 length 127", 0, 0, 0, 127, ID_D);
    run("R2 length past buffer end", 0, 100, 0, 157, ID_D);
    run("R3 id all zeros", 0, 0, 0, 128, 64'h0);
    run("R3 id all ones", 0, 0, 0, 128, '1);
    run("R4 fill last slot", 0, 8, 0, 140, ID_D);
    run("R5 store full", 0, 0, 0, 128, ID_E);
    run("R10 read B", 1, 0, ID_B, 0, 0);
    run("R8 zero id resolves to first", 1, 0, 64'h0, 0, 0);
    run("R8 R10 zero id long stored record at offset 32", 1, 32, 64'h0, 0, 0);
    run("R8 id all ones", 1, 0, '1, 0, 0);
    run("R9 read miss", 1, 0, 64'h77, 0, 0);
    run("R1 read offset 200", 1, 200, ID_B, 0, 0);
    pq.push_back({1'b1, 13'h0, 10'(3 * BUF + 20), 8'd40});
    pq.push_back({1'b1, 13'h0, 10'(3 * BUF + 21), 8'd0});
    @(negedge clk); @(negedge clk);
    run("R10 stored length too short", 1, 0, ID_D, 0, 0);
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!ended) begin
      ended = 1'b1; nchk++; nbad++;
      $display("FAIL R11 watchdog expired: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
      $finish;
    end
  end
endmodule